// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block sits between a byte-wide host bus and three counting channels of an interval timer. The host reaches it through a 2-bit address. Addresses 0 to 2 select a channel's count register and address 3 selects the control register. The block decodes control words, programs each channel's access style, counting mode and BCD flag, and assembles count bytes into 16-bit load values. It then hands each finished value to its counter with a one-cycle strobe.

On the read side the block takes snapshots of counts and of status, on one channel or on several at once. It keeps a separate byte order for reads and for writes on every channel, so the host can read 16-bit values one byte at a time. The counting logic is not part of the block. Each channel supplies its live count and its output level as inputs.

The interface is a plain register port and has no back-pressure. A write is taken in any cycle where `wr_en` is high, and a read is taken in any cycle where `rd_en` is high. The read byte appears on `rd_data` one cycle after the read strobe and holds there until the next read. The host issues at most one of the two strobes in a cycle.

Top module: `timer_host_if`

## Requirements
- R1: After reset every channel has counting mode 0, BCD flag 0, two-byte access, empty snapshots and both byte pointers at the low byte. `rd_data` is 0 and no load strobe is active.
- R2: A write to address 3 with bits 7:6 below 3 and bits 5:4 nonzero programs the channel named by bits 7:6. Bits 5:4 set its access style (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 set its counting mode and bit 0 sets its BCD flag. The write also returns both of that channel's byte pointers to the low byte. Counting mode and BCD outputs change only through such a write.
- R3: A control word with bits 5:4 = 0 snapshots the live count of the channel named by bits 7:6 and leaves that channel's mode, BCD and access style unchanged. A snapshot command is ignored while an unread count snapshot is held.
- R4: A control word with bits 7:6 = 3 is a multi-channel snapshot command. Bit 1 selects channel 0, bit 2 selects channel 1 and bit 3 selects channel 2. Bit 5 = 0 requests a count snapshot and bit 4 = 0 requests a status snapshot for every selected channel. A status request is ignored while an unread status byte is held. A count request follows the rule in R3.
- R5: The status byte holds the channel's output level in bit 7 and 0 in bit 6. Bits 5:4 hold the access style, bits 3:1 the counting mode and bit 0 the BCD flag. All of these are taken in the cycle of the command.
- R6: A read of a channel returns its held status byte first and then drops it. If no status byte is held, the read returns the held count snapshot. If neither is held, it returns the live count.
- R7: A count snapshot is read in the access style that was current when it was taken. In two-byte style the low byte comes first, then the high byte, and the snapshot is dropped after the high byte. In a single-byte style the snapshot is dropped after one read.
- R8: A count write in low-only style loads {0x00, byte}. In high-only style it loads {byte, 0x00}. In two-byte style the first byte is held and the load {second, first} happens on the second write.
- R9: Each completed count write raises that channel's `load_stb` bit for exactly the next cycle, with the 16-bit value on its `load_value` slice. At most one strobe is active at a time.
- R10: Live-count reads return the low byte in low-only style and the high byte in high-only style. In two-byte style they alternate low, high, low, and so on.
- R11: A read of address 3 returns 0. `rd_data` changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address: 0 to 2 for channels, 3 for control |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| live_count | input | NCH*16 | Live count of each channel, channel 0 in the low slice |
| out_level | input | NCH | Output level of each channel |
| load_stb | output | NCH | One-cycle load strobe per channel |
| load_value | output | NCH*16 | Load value per channel |
| count_mode | output | NCH*3 | Counting mode per channel |
| bcd_sel | output | NCH | BCD flag per channel |

## Verification
The hardest state to reach is one where a channel holds a status byte and a count snapshot together, both taken under a single-byte access style. A second command then arrives and must be ignored while both are still unread. The bench programs the style first and issues a multi-channel snapshot over two channels. It changes the live count and output level, repeats the command, and then drains the reads one byte at a time. A behavioural reference model checks every read. A long random phase then mixes control words, partial two-byte writes and reads, so that pointer resets can land in the middle of a byte pair.

// File: rtl/tmh_pkg.sv
package tmh_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_PAIR = 2'd3
  } acc_e;

  typedef struct packed {
    logic prog;
    logic cnt_snap;
    logic stat_snap;
    logic data_wr;
  } chan_cmd_t;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_fields_t;

endpackage

// File: rtl/tmh_cmd_decode.sv
module tmh_cmd_decode
  import tmh_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [7:0]            wdata,
  output chan_cmd_t [NCH-1:0]   cmd_o,
  output ctrl_fields_t          fields_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] MULTI_SEL = 2'd3;

  logic       is_ctrl;
  logic       is_multi;
  logic [1:0] sel;
  logic       acc_zero;

  assign is_ctrl  = wr_en && (addr == CTRL_ADDR);
  assign sel      = wdata[7:6];
  assign is_multi = (sel == MULTI_SEL);
  assign acc_zero = (wdata[5:4] == 2'd0);

  assign fields_o.acc  = acc_e'(wdata[5:4]);
  assign fields_o.mode = wdata[3:1];
  assign fields_o.bcd  = wdata[0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic named;
    logic picked;
    assign named  = is_ctrl && !is_multi && (sel == 2'(i));
    assign picked = is_ctrl && is_multi && wdata[i+1];
    assign cmd_o[i].data_wr   = wr_en && (addr == 2'(i));
    assign cmd_o[i].prog      = named && !acc_zero;
    assign cmd_o[i].cnt_snap  = (named && acc_zero) || (picked && !wdata[5]);
    assign cmd_o[i].stat_snap = picked && !wdata[4];
  end
endmodule

// File: rtl/tmh_chan.sv
module tmh_chan
  import tmh_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chan_cmd_t          cmd,
  input  ctrl_fields_t       fields,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               rd_sel,
  input  logic [CNT_W-1:0]   live_cnt,
  input  logic               out_lvl,
  output logic [BYTE_W-1:0]  rd_byte_o,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o,
  output logic [2:0]         mode_o,
  output logic               bcd_o
);
  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic              wr_hi_q;
  logic              rd_hi_q;
  logic [BYTE_W-1:0] hold_q;
  logic              cs_valid_q;
  acc_e              cs_acc_q;
  logic              cs_hi_q;
  logic [CNT_W-1:0]  cs_val_q;
  logic              st_valid_q;
  logic [7:0]        st_val_q;
  logic              load_q;
  logic [CNT_W-1:0]  load_val_q;

  // read byte selection: status, then count snapshot, then live count
  always_comb begin
    if (st_valid_q) begin
      rd_byte_o = st_val_q;
    end else if (cs_valid_q) begin
      case (cs_acc_q)
        ACC_HI:   rd_byte_o = cs_val_q[CNT_W-1:BYTE_W];
        ACC_PAIR: rd_byte_o = cs_hi_q ? cs_val_q[CNT_W-1:BYTE_W] : cs_val_q[BYTE_W-1:0];
        default:  rd_byte_o = cs_val_q[BYTE_W-1:0];
      endcase
    end else begin
      case (acc_q)
        ACC_HI:   rd_byte_o = live_cnt[CNT_W-1:BYTE_W];
        ACC_PAIR: rd_byte_o = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
        default:  rd_byte_o = live_cnt[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_PAIR;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      cs_valid_q <= 1'b0;
      cs_acc_q   <= ACC_PAIR;
      cs_hi_q    <= 1'b0;
      cs_val_q   <= '0;
      st_valid_q <= 1'b0;
      st_val_q   <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q <= 1'b0;

      if (cmd.data_wr) begin
        case (acc_q)
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata, {BYTE_W{1'b0}}};
          end
          ACC_PAIR: begin
            if (!wr_hi_q) begin
              hold_q  <= wdata;
              wr_hi_q <= 1'b1;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata, hold_q};
              wr_hi_q    <= 1'b0;
            end
          end
          default: begin
            load_q     <= 1'b1;
            load_val_q <= {{BYTE_W{1'b0}}, wdata};
          end
        endcase
      end

      if (rd_sel) begin
        if (st_valid_q) begin
          st_valid_q <= 1'b0;
        end else if (cs_valid_q) begin
          if (cs_acc_q == ACC_PAIR && !cs_hi_q) cs_hi_q <= 1'b1;
          else                                  cs_valid_q <= 1'b0;
        end else if (acc_q == ACC_PAIR) begin
          rd_hi_q <= !rd_hi_q;
        end
      end

      if (cmd.prog) begin
        acc_q   <= fields.acc;
        mode_q  <= fields.mode;
        bcd_q   <= fields.bcd;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end

      if (cmd.cnt_snap && !cs_valid_q) begin
        cs_valid_q <= 1'b1;
        cs_acc_q   <= acc_q;
        cs_hi_q    <= 1'b0;
        cs_val_q   <= live_cnt;
      end

      if (cmd.stat_snap && !st_valid_q) begin
        st_valid_q <= 1'b1;
        st_val_q   <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
      end
    end
  end

  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign mode_o     = mode_q;
  assign bcd_o      = bcd_q;
endmodule

// File: rtl/tmh_rd_path.sv
module tmh_rd_path #(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [1:0]                   addr,
  input  logic [NCH-1:0][BYTE_W-1:0]   chan_bytes,
  output logic [NCH-1:0]               rd_sel_o,
  output logic [BYTE_W-1:0]            rd_data_o
);
  logic [BYTE_W-1:0] mux_byte;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign rd_sel_o[i] = rd_en && (addr == 2'(i));
  end

  always_comb begin
    mux_byte = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) mux_byte = chan_bytes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data_o <= '0;
    else if (rd_en) rd_data_o <= mux_byte;
  end
endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
  import tmh_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic [NCH*CNT_W-1:0] live_count,
  input  logic [NCH-1:0]     out_level,
  output logic [NCH-1:0]     load_stb,
  output logic [NCH*CNT_W-1:0] load_value,
  output logic [NCH*3-1:0]   count_mode,
  output logic [NCH-1:0]     bcd_sel
);
  chan_cmd_t [NCH-1:0]              cmds;
  ctrl_fields_t                     fields;
  logic [NCH-1:0]                   rd_sel;
  logic [NCH-1:0][BYTE_W-1:0]       chan_bytes;

  tmh_cmd_decode #(.NCH(NCH)) u_dec (
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wr_data),
    .cmd_o    (cmds),
    .fields_o (fields)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    tmh_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmds[i]),
      .fields     (fields),
      .wdata      (wr_data),
      .rd_sel     (rd_sel[i]),
      .live_cnt   (live_count[i*CNT_W +: CNT_W]),
      .out_lvl    (out_level[i]),
      .rd_byte_o  (chan_bytes[i]),
      .load_o     (load_stb[i]),
      .load_val_o (load_value[i*CNT_W +: CNT_W]),
      .mode_o     (count_mode[i*3 +: 3]),
      .bcd_o      (bcd_sel[i])
    );
  end

  tmh_rd_path #(.NCH(NCH), .BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .chan_bytes (chan_bytes),
    .rd_sel_o   (rd_sel),
    .rd_data_o  (rd_data)
  );
endmodule

// File: rtl/tmh_checker.sv
module tmh_checker #(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [1:0]           addr,
  input logic [BYTE_W-1:0]    rd_data,
  input logic [NCH-1:0]       load_stb,
  input logic [NCH*3-1:0]     count_mode,
  input logic [NCH-1:0]       bcd_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_stb
    a_r9_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[i] |-> $past(wr_en && addr == 2'(i)));
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  a_r11_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rd_data == '0));

  a_r11_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r2_mode_by_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd3) |=> ($stable(count_mode) && $stable(bcd_sel)));
endmodule

bind timer_host_if tmh_checker #(.NCH(NCH), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .rd_data    (rd_data),
  .load_stb   (load_stb),
  .count_mode (count_mode),
  .bcd_sel    (bcd_sel)
);

// File: tb/test_timer_host_if.sv
module test_timer_host_if;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [NCH*16-1:0] live_count = '0;
  logic [NCH-1:0] out_level = '0;
  logic [NCH-1:0] load_stb;
  logic [NCH*16-1:0] load_value;
  logic [NCH*3-1:0] count_mode;
  logic [NCH-1:0] bcd_sel;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  timer_host_if i_timer_host_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .live_count(live_count),
    .out_level(out_level), .load_stb(load_stb), .load_value(load_value),
    .count_mode(count_mode), .bcd_sel(bcd_sel)
  );

  // behavioural reference model
  int m_acc[NCH], m_mode[NCH], m_bcd[NCH];
  bit m_wrhi[NCH], m_rdhi[NCH];
  int m_hold[NCH];
  bit m_cs[NCH]; int m_csacc[NCH]; bit m_cshi[NCH]; int m_csval[NCH];
  bit m_st[NCH]; int m_stval[NCH];
  int e_rd;
  bit e_stb[NCH]; int e_lval[NCH];

  function automatic int live_of(int c);
    return int'(live_count[c*16 +: 16]);
  endfunction

  function automatic int model_read(int c);
    int v, lo, hi;
    if (m_st[c]) begin
      m_st[c] = 0;
      return m_stval[c];
    end
    if (m_cs[c]) begin
      lo = m_csval[c] % 256; hi = m_csval[c] / 256;
      if (m_csacc[c] == 2) begin m_cs[c] = 0; return hi; end
      if (m_csacc[c] == 3 && !m_cshi[c]) begin m_cshi[c] = 1; return lo; end
      m_cs[c] = 0;
      return (m_csacc[c] == 3) ? hi : lo;
    end
    v = live_of(c);
    if (m_acc[c] == 1) return v % 256;
    if (m_acc[c] == 2) return v / 256;
    m_rdhi[c] = !m_rdhi[c];
    return m_rdhi[c] ? v % 256 : v / 256;
  endfunction

  task automatic snap_count(int c);
    if (!m_cs[c]) begin
      m_cs[c] = 1; m_csacc[c] = m_acc[c]; m_cshi[c] = 0; m_csval[c] = live_of(c);
    end
  endtask

  task automatic snap_status(int c);
    if (!m_st[c]) begin
      m_st[c] = 1;
      m_stval[c] = out_level[c] * 128 + m_acc[c] * 16 + m_mode[c] * 2 + m_bcd[c];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wrhi[c] = 0; m_rdhi[c] = 0;
        m_hold[c] = 0; m_cs[c] = 0; m_st[c] = 0; e_stb[c] = 0; e_lval[c] = 0;
      end
      e_rd = 0;
    end else begin
      for (int c = 0; c < NCH; c++) e_stb[c] = 0;
      if (rd_en) e_rd = (addr == 3) ? 0 : model_read(int'(addr));
      if (wr_en && addr != 3) begin
        automatic int c = int'(addr);
        automatic int d = int'(wr_data);
        if (m_acc[c] == 1) begin e_stb[c] = 1; e_lval[c] = d; end
        else if (m_acc[c] == 2) begin e_stb[c] = 1; e_lval[c] = d * 256; end
        else if (!m_wrhi[c]) begin m_hold[c] = d; m_wrhi[c] = 1; end
        else begin e_stb[c] = 1; e_lval[c] = d * 256 + m_hold[c]; m_wrhi[c] = 0; end
      end else if (wr_en) begin
        automatic int s = int'(wr_data[7:6]);
        automatic int a = int'(wr_data[5:4]);
        if (s == 3) begin
          for (int c = 0; c < NCH; c++) if (wr_data[c+1]) begin
            if (!wr_data[5]) snap_count(c);
            if (!wr_data[4]) snap_status(c);
          end
        end else if (a == 0) begin
          snap_count(s);
        end else begin
          m_acc[s] = a; m_mode[s] = int'(wr_data[3:1]); m_bcd[s] = wr_data[0];
          m_wrhi[s] = 0; m_rdhi[s] = 0;
        end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("rd_data", int'(rd_data), e_rd);
      for (int c = 0; c < NCH; c++) begin
        check("load_stb", int'(load_stb[c]), int'(e_stb[c]));
        if (e_stb[c]) check("load_value", int'(load_value[c*16 +: 16]), e_lval[c]);
        check("count_mode", int'(count_mode[c*3 +: 3]), m_mode[c]);
        check("bcd_sel", int'(bcd_sel[c]), m_bcd[c]);
      end
    end
  end

  // one bus cycle: inputs applied 2 ns after the edge
  task automatic cyc(bit w, bit r, logic [1:0] a, logic [7:0] d, bit bump = 1);
    @(posedge clk); #2;
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    if (bump) begin
      live_count = {16'($urandom), 16'($urandom), 16'($urandom)};
      out_level  = 3'($urandom);
    end
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(logic [1:0] a);                cyc(0, 1, a, 8'h00); endtask
  task automatic idle();                           cyc(0, 0, 2'd0, 8'h00); endtask

  initial begin
    repeat (60000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("rd_data", int'(rd_data), 0);
    check("load_stb", int'(load_stb), 0);
    check("count_mode", int'(count_mode), 0);
    check("bcd_sel", int'(bcd_sel), 0);
    wr(2'd0, 8'h34); wr(2'd0, 8'h12); idle();   // default two-byte style

    cur_req = "R8";
    wr(2'd3, 8'h54); wr(2'd1, 8'hAB); idle();   // ch1 low-only, mode 2
    wr(2'd3, 8'hA7); wr(2'd2, 8'h5C); idle();   // ch2 high-only, mode 3, BCD
    cur_req = "R9";
    wr(2'd1, 8'h01); wr(2'd2, 8'h02); wr(2'd0, 8'h03); idle(); wr(2'd0, 8'h04); idle();

    cur_req = "R10";
    for (int k = 0; k < 4; k++) begin rd(2'd0); rd(2'd1); rd(2'd2); end
    idle();

    cur_req = "R3";
    wr(2'd3, 8'h00); rd(2'd0); rd(2'd0); idle();
    wr(2'd3, 8'h00); idle(); wr(2'd3, 8'h00); idle(); rd(2'd0); rd(2'd0); idle();
    wr(2'd3, 8'h40); wr(2'd3, 8'h40); rd(2'd1); rd(2'd1); idle();

    cur_req = "R4";
    wr(2'd3, 8'hCA); idle(); wr(2'd3, 8'hCA); idle();
    cur_req = "R6";
    rd(2'd0); rd(2'd0); rd(2'd0); rd(2'd0); rd(2'd2); rd(2'd2); rd(2'd2); idle();
    cur_req = "R5";
    wr(2'd3, 8'hEE); wr(2'd3, 8'hEE); rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd1); idle();
    cur_req = "R7";
    wr(2'd3, 8'hDE); wr(2'd3, 8'h6C); rd(2'd1); rd(2'd1); rd(2'd0); rd(2'd0); rd(2'd0);
    rd(2'd2); rd(2'd2); idle();

    cur_req = "R2";
    wr(2'd0, 8'h11); wr(2'd3, 8'h3B); wr(2'd0, 8'h22); wr(2'd0, 8'h33); idle();
    rd(2'd0); wr(2'd3, 8'h30); rd(2'd0); rd(2'd0); idle();

    cur_req = "R11";
    rd(2'd3); idle(); idle(); rd(2'd0); idle(); rd(2'd3); idle();

    cur_req = "R6";
    for (int k = 0; k < 3000; k++) begin
      automatic int op = int'($urandom % 8);
      automatic logic [1:0] a = 2'($urandom);
      if (op < 3)      wr(a, 8'($urandom));
      else if (op < 6) rd(a);
      else             idle();
    end
    idle(); idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule